// File: doc/BRIEF.md
# Interrupt Request Acceptance Controller

This block decides, cycle by cycle, whether the processor core takes an interrupt. It watches two request sources. The first is a non-maskable request pin, on which a request is a high-to-low transition. The second is a maskable request pin that comes with a priority level. Both pins and the level bus are registered on the bus clock before any decision uses them.

A falling edge on the non-maskable pin is held as pending until the core reaches a point where it may take an interrupt. The maskable request is not stored. At each such point it is qualified again against three core status flags (nested-exception, exception-pending and interrupt-disable) and against the permit-level threshold. The core marks those points with a strobe that is high at the end of an instruction or while no internal processing is running. When a request is taken, the block gives a one-cycle accept pulse together with a source indicator and the level that applied.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), accept, accept_is_nmi and accept_level are all 0.
- R2: A non-maskable request is recognised only when the registered nmi_pin value goes from 1 to 0. A rising edge, or a pin held low, creates no request.
- R3: A recognised non-maskable request stays pending through any number of cycles without a check point. It is accepted at the next check point and then cleared, so each falling edge gives exactly one accept.
- R4: When a non-maskable request and a qualifying maskable request meet at the same check point, the non-maskable one is accepted. The maskable one is accepted at a later check point if it still qualifies.
- R5: A maskable request is accepted only when flag_np, flag_ep and flag_id are all 0 at the check point.
- R6: A maskable request is accepted only when its registered level is numerically greater than permit_level, compared as unsigned 4-bit values. An equal level is refused.
- R7: A maskable request is accepted only while the registered int_req is 1.
- R8: Requests are accepted only at check points. accept is high in a cycle only if chk_point was high at the clock edge that started that cycle.
- R9: accept is high for exactly the one cycle after each qualifying check point. With it, accept_is_nmi is 1 for a non-maskable accept and 0 for a maskable one. accept_level holds the registered level for a maskable accept and 0 for a non-maskable accept. While accept is low, accept_is_nmi and accept_level are 0.
- R10: int_level is sampled on every clock. If a waiting maskable request has its level raised, the raised level decides acceptance and is the level reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi_pin | input | 1 | Non-maskable request pin; a request is a falling edge |
| int_req | input | 1 | Maskable request, active high |
| int_level | input | 4 | Priority level of the maskable request |
| flag_np | input | 1 | Nested-exception status flag |
| flag_ep | input | 1 | Exception-pending status flag |
| flag_id | input | 1 | Interrupt-disable status flag |
| permit_level | input | 4 | Threshold a maskable level must exceed |
| chk_point | input | 1 | High at instruction end or while the core is idle |
| accept | output | 1 | One-cycle accept pulse |
| accept_is_nmi | output | 1 | 1 when the accepted request is non-maskable |
| accept_level | output | 4 | Level of the accepted maskable request, else 0 |

## Verification
The assertions assume that the status flags and permit_level are stable, valid core state at each clock edge. They are compared directly at the check point, with no register in between, so an accept is related to their values in the cycle before. The assertions also assume that a maskable source keeps int_req asserted until it is accepted. The stimulus keeps to these assumptions: it changes every input only on the falling clock edge, and it holds each request setting for at least one full clock before it raises a check point. The sweeps cover every level against every permit level, and every combination of the three flags.

// File: rtl/irq_accept_pkg.sv
// Package: shared constants and the accept source encoding for the
// interrupt acceptance controller.
package irq_accept_pkg;
    // Default width of the priority level and of the permit threshold.
    localparam int IRQ_LVL_W = 4;

    // Source of an accepted request.
    typedef enum logic {
        SRC_MASKABLE = 1'b0,
        SRC_NMI      = 1'b1
    } irq_src_e;
endpackage

// File: rtl/irq_pin_sampler.sv
// Module: irq_pin_sampler
// Registers the request pins and the level bus on the bus clock. It also
// keeps the previous sampled value of the non-maskable pin so that an
// edge can be found on registered data only.
// Assumes: the pins are already synchronous to clk.
module irq_pin_sampler #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             int_req,
    input  logic [LVL_W-1:0] int_level,
    output logic             nmi_now,
    output logic             nmi_prev,
    output logic             int_now,
    output logic [LVL_W-1:0] lvl_now
);
    // Sample all pins; the non-maskable history resets high so that no edge appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_now  <= 1'b1;
            nmi_prev <= 1'b1;
            int_now  <= 1'b0;
            lvl_now  <= '0;
        end else begin
            nmi_now  <= nmi_pin;
            nmi_prev <= nmi_now;
            int_now  <= int_req;
            lvl_now  <= int_level;
        end
    end
endmodule

// File: rtl/irq_nmi_tracker.sv
// Module: irq_nmi_tracker
// Finds falling edges of the sampled non-maskable pin and holds one
// pending request until the arbiter takes it.
// Assumes: take is asserted only while req is high.
module irq_nmi_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_now,
    input  logic nmi_prev,
    input  logic take,
    output logic req
);
    logic fall;
    logic pend_q;

    // An edge is a 1 in the previous sample followed by a 0 now.
    always_comb fall = nmi_prev && !nmi_now;

    // A fresh edge counts at once, without waiting for the pending bit.
    always_comb req = pend_q || fall;

    // Hold the request until it is taken at a check point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= req && !take;
        end
    end
endmodule

// File: rtl/irq_mask_qualifier.sv
// Module: irq_mask_qualifier
// Decides whether the sampled maskable request may be taken. All three
// status flags must be clear, the request must be active, and its level
// must be strictly above the permit threshold (unsigned).
// Assumes: the flags and the threshold are valid core state each cycle.
module irq_mask_qualifier #(
    parameter int LVL_W = 4
) (
    input  logic             int_now,
    input  logic [LVL_W-1:0] lvl_now,
    input  logic             flag_np,
    input  logic             flag_ep,
    input  logic             flag_id,
    input  logic [LVL_W-1:0] permit_level,
    output logic             ok
);
    logic flags_clear;
    logic above;

    // Core status must leave interrupts open.
    always_comb flags_clear = !(flag_np || flag_ep || flag_id);

    // Priority comparison, unsigned and strict.
    always_comb above = lvl_now > permit_level;

    // All three conditions at once.
    always_comb ok = int_now && flags_clear && above;
endmodule

// File: rtl/irq_accept_ctrl.sv
// Module: irq_accept_ctrl (top)
// Samples the request pins, tracks non-maskable edges, qualifies the
// maskable request, and at each check point registers a one-cycle
// accept with its source and level. Non-maskable wins over maskable.
// Assumes: chk_point marks instruction ends or idle cycles of the core.
module irq_accept_ctrl #(
    parameter int LVL_W = irq_accept_pkg::IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             int_req,
    input  logic [LVL_W-1:0] int_level,
    input  logic             flag_np,
    input  logic             flag_ep,
    input  logic             flag_id,
    input  logic [LVL_W-1:0] permit_level,
    input  logic             chk_point,
    output logic             accept,
    output logic             accept_is_nmi,
    output logic [LVL_W-1:0] accept_level
);
    import irq_accept_pkg::*;

    logic             nmi_now;
    logic             nmi_prev;
    logic             int_now;
    logic [LVL_W-1:0] lvl_now;
    logic             nmi_req;
    logic             mask_ok;
    logic             take_nmi;
    logic             take_mask;
    irq_src_e         src;

    irq_pin_sampler #(.LVL_W(LVL_W)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_pin   (nmi_pin),
        .int_req   (int_req),
        .int_level (int_level),
        .nmi_now   (nmi_now),
        .nmi_prev  (nmi_prev),
        .int_now   (int_now),
        .lvl_now   (lvl_now)
    );

    irq_nmi_tracker u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_now  (nmi_now),
        .nmi_prev (nmi_prev),
        .take     (take_nmi),
        .req      (nmi_req)
    );

    irq_mask_qualifier #(.LVL_W(LVL_W)) u_qual (
        .int_now      (int_now),
        .lvl_now      (lvl_now),
        .flag_np      (flag_np),
        .flag_ep      (flag_ep),
        .flag_id      (flag_id),
        .permit_level (permit_level),
        .ok           (mask_ok)
    );

    // Arbitration at a check point: non-maskable first.
    always_comb begin
        take_nmi  = chk_point && nmi_req;
        take_mask = chk_point && !nmi_req && mask_ok;
        src       = take_nmi ? SRC_NMI : SRC_MASKABLE;
    end

    // Register the accept pulse with its source and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept        <= 1'b0;
            accept_is_nmi <= 1'b0;
            accept_level  <= '0;
        end else begin
            accept        <= take_nmi || take_mask;
            accept_is_nmi <= (src == SRC_NMI);
            accept_level  <= take_mask ? lvl_now : '0;
        end
    end
endmodule

// File: rtl/irq_accept_checker.sv
// Module: irq_accept_checker
// Temporal checks on the ports of irq_accept_ctrl, attached by bind.
module irq_accept_checker #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_np,
    input logic             flag_ep,
    input logic             flag_id,
    input logic [LVL_W-1:0] permit_level,
    input logic             chk_point,
    input logic             accept,
    input logic             accept_is_nmi,
    input logic [LVL_W-1:0] accept_level
);
    AST_ONLY_AT_CHECK_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(chk_point)); // R8

    AST_MASK_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !accept_is_nmi) |-> $past(!flag_np && !flag_ep && !flag_id)); // R5

    AST_MASK_ABOVE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !accept_is_nmi) |-> (accept_level > $past(permit_level))); // R6

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (!accept_is_nmi && accept_level == '0)); // R9

    AST_NMI_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_is_nmi) |-> (accept_level == '0)); // R9
endmodule

bind irq_accept_ctrl irq_accept_checker #(.LVL_W(LVL_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flag_np       (flag_np),
    .flag_ep       (flag_ep),
    .flag_id       (flag_id),
    .permit_level  (permit_level),
    .chk_point     (chk_point),
    .accept        (accept),
    .accept_is_nmi (accept_is_nmi),
    .accept_level  (accept_level)
);

// File: tb/irq_accept_ctrl_test.sv
`timescale 1ns/1ps
module irq_accept_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       nmi_pin;
    logic       int_req;
    logic [3:0] int_level;
    logic       flag_np;
    logic       flag_ep;
    logic       flag_id;
    logic [3:0] permit_level;
    logic       chk_point;
    logic       accept;
    logic       accept_is_nmi;
    logic [3:0] accept_level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_accept_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .nmi_pin       (nmi_pin),
        .int_req       (int_req),
        .int_level     (int_level),
        .flag_np       (flag_np),
        .flag_ep       (flag_ep),
        .flag_id       (flag_id),
        .permit_level  (permit_level),
        .chk_point     (chk_point),
        .accept        (accept),
        .accept_is_nmi (accept_is_nmi),
        .accept_level  (accept_level)
    );

    // Compare all three outputs against expectations.
    task automatic expect_out(input bit e_acc, input bit e_nmi, input logic [3:0] e_lvl,
                              input string tag);
        checks++;
        if (accept !== e_acc || accept_is_nmi !== e_nmi || accept_level !== e_lvl) begin
            errors++;
            $display("FAIL %s: got acc=%0b nmi=%0b lvl=%0d, expected acc=%0b nmi=%0b lvl=%0d",
                     tag, accept, accept_is_nmi, accept_level, e_acc, e_nmi, e_lvl);
        end
    endtask

    // Let one clock pass so that new pin values are sampled; ends at a negedge.
    task automatic settle();
        @(negedge clk);
    endtask

    // Raise the check point for one edge, then check the registered result.
    task automatic check_point(input bit e_acc, input bit e_nmi, input logic [3:0] e_lvl,
                               input string tag);
        chk_point = 1'b1;
        @(negedge clk);
        chk_point = 1'b0;
        expect_out(e_acc, e_nmi, e_lvl, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; nmi_pin = 1'b1; int_req = 1'b0; int_level = 4'd0;
        flag_np = 1'b0; flag_ep = 1'b0; flag_id = 1'b0; permit_level = 4'd0;
        chk_point = 1'b0;
        repeat (3) @(negedge clk);
        expect_out(1'b0, 1'b0, 4'd0, "R1 reset state");
        rst_n = 1'b1;
        settle();

        // R6 R9 R7: sweep every level against every permit level.
        int_req = 1'b1;
        for (int lv = 0; lv < 16; lv++) begin
            for (int pm = 0; pm < 16; pm++) begin
                int_level = 4'(lv); permit_level = 4'(pm);
                settle();
                if (lv > pm) check_point(1'b1, 1'b0, 4'(lv), "R6 level above permit");
                else         check_point(1'b0, 1'b0, 4'd0, "R6 level not above permit");
            end
        end

        // R5: every flag combination with a qualifying level.
        int_level = 4'd9; permit_level = 4'd2;
        for (int f = 0; f < 8; f++) begin
            {flag_np, flag_ep, flag_id} = 3'(f);
            settle();
            if (f == 0) check_point(1'b1, 1'b0, 4'd9, "R5 flags clear");
            else        check_point(1'b0, 1'b0, 4'd0, "R5 flag set blocks");
        end
        {flag_np, flag_ep, flag_id} = 3'b000;

        // R7: an inactive request is refused.
        int_req = 1'b0;
        settle();
        check_point(1'b0, 1'b0, 4'd0, "R7 request inactive");

        // R8: a qualifying request without check points is never accepted.
        int_req = 1'b1;
        settle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            expect_out(1'b0, 1'b0, 4'd0, "R8 no check point");
        end
        // R9: a pulse per check point, low again afterwards.
        check_point(1'b1, 1'b0, 4'd9, "R9 accept pulse");
        @(negedge clk);
        expect_out(1'b0, 1'b0, 4'd0, "R9 pulse one cycle");

        // R10: a waiting request with its level raised.
        int_level = 4'd3; permit_level = 4'd5;
        settle();
        check_point(1'b0, 1'b0, 4'd0, "R10 low level waits");
        int_level = 4'd11;
        settle();
        check_point(1'b1, 1'b0, 4'd11, "R10 raised level reported");
        int_req = 1'b0;

        // R2 R3: a falling edge held pending across idle cycles.
        nmi_pin = 1'b0;
        repeat (5) begin
            @(negedge clk);
            expect_out(1'b0, 1'b0, 4'd0, "R3 pending without check point");
        end
        check_point(1'b1, 1'b1, 4'd0, "R3 pending NMI accepted");
        settle();
        check_point(1'b0, 1'b0, 4'd0, "R3 NMI cleared after accept");
        // R2: the rising edge and a held level create no request.
        nmi_pin = 1'b1;
        settle();
        check_point(1'b0, 1'b0, 4'd0, "R2 rising edge ignored");
        check_point(1'b0, 1'b0, 4'd0, "R2 high level ignored");
        // R2: an edge followed at once by a check point.
        nmi_pin = 1'b0;
        settle();
        check_point(1'b1, 1'b1, 4'd0, "R2 falling edge accepted");
        check_point(1'b0, 1'b0, 4'd0, "R2 held low ignored");

        // R4: both sources at one check point.
        nmi_pin = 1'b1;
        settle();
        settle();
        int_req = 1'b1; int_level = 4'd14; permit_level = 4'd1;
        nmi_pin = 1'b0;
        settle();
        check_point(1'b1, 1'b1, 4'd0, "R4 NMI first");
        check_point(1'b1, 1'b0, 4'd14, "R4 maskable afterwards");
        int_req = 1'b0;
        settle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule